// File: doc/BRIEF.md
# Word-Granular Memory-to-Memory DMA Engine

This block moves a contiguous run of 16-bit words from one memory region to another without processor involvement. Software programs it through a small byte-wide I/O register file: a 20-bit source address, a 16-bit destination address, a 16-bit byte count and a control byte holding an enable flag and a direction flag. Setting the enable flag starts the engine. It then copies one word per step over a simple byte-wide memory master port.

Each copy step performs four single-byte accesses in a fixed order: read, write, read, write. The engine then moves both addresses by two, up or down as the direction flag selects, and lowers the byte count by two. Before every step the engine checks two stop conditions: the count has reached zero, or the source points into memory bank 1, which is the battery-backed static RAM bank and is never used as a source. When either holds, the engine clears its own enable flag and makes no memory access.

Every step reports its cost in processor stall cycles on a pulse output. A surrounding system model can add these costs up to charge the processor for the transfer.

Top module: `wdma_engine`

## Requirements
- R1: The registers answer at fixed I/O addresses: source bits 7:0 at 0x40, bits 15:8 at 0x41 and bits 19:16 at 0x42, destination low and high bytes at 0x44 and 0x45, count low and high bytes at 0x46 and 0x47, and control at 0x48. Writing one byte of a multi-byte register leaves its other bytes unchanged.
- R2: Bit 0 of the source, destination and count is forced to zero on every write, so it always reads back as zero.
- R3: The 0x42 register stores only the low four bits written to it. Reading it returns those bits in bits 3:0, with bits 7:4 zero.
- R4: Control bit 7 is the enable flag and bit 6 selects decrement mode (1 = addresses count down). Control bits 5:0 are discarded on write and read as zero.
- R5: At each step taken while enabled, if the count is zero or source bits 19:16 equal 1, the engine clears the enable flag, makes no memory access and reports a cost of 5. The decrement flag keeps its value.
- R6: Each copy step reads the source, then writes that byte to the destination, then reads source+1, then writes that byte to destination+1. The engine makes one access per clock, and read data arrives one clock after the read.
- R7: After each copied word, the source and destination both rise by 2 (or fall by 2 in decrement mode) and the count falls by 2. The step reports a cost of 2.
- R8: When stepped, the destination wraps modulo 2^16 and the source wraps modulo 2^20. The memory port drives the destination with bits 19:16 equal to zero.
- R9: The busy output equals the enable flag. Reset clears every register to zero and leaves the memory port idle.
- R10: I/O addresses outside the nine mapped ones read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| io_wr | input | 1 | Register write strobe for one clock |
| io_addr | input | 8 | Register I/O address, for both reads and writes |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data, combinational from io_addr |
| mem_req | output | 1 | Memory access request, one byte per clock |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the clock after a read |
| busy | output | 1 | Engine enabled |
| step_done | output | 1 | One-clock pulse when a step completes |
| step_cost | output | 3 | Stall cycles for the step flagged by step_done |

## Verification
The copy function is exercised with several transfer shapes:
- An ascending run over mid-range addresses, which shows the access order and stepping direction.
- A descending run, which separates increment from decrement.
- Runs that wrap the source past 0xFFFFF and the destination past 0xFFFF, which show each address's own modulus.
- A run whose source crosses into bank 1 partway through, which shows that the bank test is made again at every step and not only at the start.

A zero count and a source that starts in bank 1 both isolate the stop path: they must produce no memory traffic and a single cost of 5. The memory model returns an address-derived byte for every read, so a wrong address, a swapped access order or an extra access each shows up in the logged access sequence.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  // Address widths fixed by the register map
  localparam int SRC_W  = 20;
  localparam int DST_W  = 16;
  localparam int LEN_W  = 16;
  localparam int IO_AW  = 8;
  localparam int BYTE_W = 8;
  localparam int COST_W = 3;

  // I/O port addresses
  localparam logic [IO_AW-1:0] PA_SRC_L = 8'h40;
  localparam logic [IO_AW-1:0] PA_SRC_M = 8'h41;
  localparam logic [IO_AW-1:0] PA_SRC_H = 8'h42;
  localparam logic [IO_AW-1:0] PA_DST_L = 8'h44;
  localparam logic [IO_AW-1:0] PA_DST_H = 8'h45;
  localparam logic [IO_AW-1:0] PA_LEN_L = 8'h46;
  localparam logic [IO_AW-1:0] PA_LEN_H = 8'h47;
  localparam logic [IO_AW-1:0] PA_CTRL  = 8'h48;

  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_DEC_BIT = 6;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD0  = 3'd1,
    ST_WR0  = 3'd2,
    ST_RD1  = 3'd3,
    ST_WR1  = 3'd4
  } wdma_state_e;
endpackage

// File: rtl/wdma_regs.sv
module wdma_regs
  import wdma_pkg::*;
#(
  parameter int WORD_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [BYTE_W-1:0] io_wdata,
  output logic [BYTE_W-1:0] io_rdata,
  input  logic              adv,
  input  logic              term,
  output logic [SRC_W-1:0]  src_q,
  output logic [DST_W-1:0]  dst_q,
  output logic [LEN_W-1:0]  len_q,
  output logic              en_q,
  output logic              dec_q
);
  localparam int HI_W = SRC_W - 16;

  logic [SRC_W-1:0] src_d;
  logic [DST_W-1:0] dst_d;
  logic [LEN_W-1:0] len_d;
  logic             en_d, dec_d;
  logic             wr_src, wr_dst, wr_len, wr_ctl;
  logic             src_ce, dst_ce, len_ce, ctl_ce;
  logic             unused_wbits;

  assign unused_wbits = ^{io_wdata[CTRL_DEC_BIT-1:0]};

  // Write decode and clock enables
  always_comb begin
    wr_src = io_wr && (io_addr == PA_SRC_L || io_addr == PA_SRC_M || io_addr == PA_SRC_H);
    wr_dst = io_wr && (io_addr == PA_DST_L || io_addr == PA_DST_H);
    wr_len = io_wr && (io_addr == PA_LEN_L || io_addr == PA_LEN_H);
    wr_ctl = io_wr && (io_addr == PA_CTRL);
    src_ce = adv | wr_src;
    dst_ce = adv | wr_dst;
    len_ce = adv | wr_len;
    ctl_ce = term | wr_ctl;
  end

  // Next state: engine stepping first, then byte-lane overlay of port writes
  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    len_d = len_q;
    if (adv) begin
      src_d = dec_q ? src_q - SRC_W'(WORD_STEP) : src_q + SRC_W'(WORD_STEP);
      dst_d = dec_q ? dst_q - DST_W'(WORD_STEP) : dst_q + DST_W'(WORD_STEP);
      len_d = len_q - LEN_W'(WORD_STEP);
    end
    if (io_wr) begin
      case (io_addr)
        PA_SRC_L: src_d[7:0]        = {io_wdata[7:1], 1'b0};
        PA_SRC_M: src_d[15:8]       = io_wdata;
        PA_SRC_H: src_d[SRC_W-1:16] = io_wdata[HI_W-1:0];
        PA_DST_L: dst_d[7:0]        = {io_wdata[7:1], 1'b0};
        PA_DST_H: dst_d[15:8]       = io_wdata;
        PA_LEN_L: len_d[7:0]        = {io_wdata[7:1], 1'b0};
        PA_LEN_H: len_d[15:8]       = io_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    en_d  = en_q;
    dec_d = dec_q;
    if (term) en_d = 1'b0;
    if (wr_ctl) begin
      en_d  = io_wdata[CTRL_EN_BIT];
      dec_d = io_wdata[CTRL_DEC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      len_q <= '0;
      en_q  <= 1'b0;
      dec_q <= 1'b0;
    end else begin
      if (src_ce) src_q <= src_d;
      if (dst_ce) dst_q <= dst_d;
      if (len_ce) len_q <= len_d;
      if (ctl_ce) begin
        en_q  <= en_d;
        dec_q <= dec_d;
      end
    end
  end

  // Read-back mux
  always_comb begin
    case (io_addr)
      PA_SRC_L: io_rdata = {src_q[7:1], 1'b0};
      PA_SRC_M: io_rdata = src_q[15:8];
      PA_SRC_H: io_rdata = {{(BYTE_W-HI_W){1'b0}}, src_q[SRC_W-1:16]};
      PA_DST_L: io_rdata = {dst_q[7:1], 1'b0};
      PA_DST_H: io_rdata = dst_q[15:8];
      PA_LEN_L: io_rdata = {len_q[7:1], 1'b0};
      PA_LEN_H: io_rdata = len_q[15:8];
      PA_CTRL:  io_rdata = {en_q, dec_q, 6'b0};
      default:  io_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdma_seq.sv
module wdma_seq
  import wdma_pkg::*;
#(
  parameter logic [3:0] SRAM_BANK = 4'h1,
  parameter int         COST_TERM = 5,
  parameter int         COST_COPY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SRC_W-1:0]  src,
  input  logic [DST_W-1:0]  dst,
  input  logic [LEN_W-1:0]  len,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [SRC_W-1:0]  mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              adv,
  output logic              term,
  output logic              step_done,
  output logic [COST_W-1:0] step_cost
);
  localparam int PAD_W = SRC_W - DST_W;

  wdma_state_e state_q, state_d;
  logic        stop_cond;
  logic [SRC_W-1:0] dst_ext;

  assign stop_cond = (len == '0) || (src[SRC_W-1:SRC_W-4] == SRAM_BANK);
  assign dst_ext   = {{PAD_W{1'b0}}, dst};

  always_comb begin
    state_d   = state_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    adv       = 1'b0;
    term      = 1'b0;
    step_done = 1'b0;
    step_cost = '0;
    case (state_q)
      ST_IDLE: begin
        if (en) begin
          if (stop_cond) begin
            term      = 1'b1;
            step_done = 1'b1;
            step_cost = COST_W'(COST_TERM);
          end else begin
            state_d = ST_RD0;
          end
        end
      end
      ST_RD0: begin
        mem_req  = 1'b1;
        mem_addr = src;
        state_d  = ST_WR0;
      end
      ST_WR0: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_ext;
        mem_wdata = mem_rdata;
        state_d   = ST_RD1;
      end
      ST_RD1: begin
        mem_req  = 1'b1;
        mem_addr = src | SRC_W'(1);
        state_d  = ST_WR1;
      end
      ST_WR1: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_ext | SRC_W'(1);
        mem_wdata = mem_rdata;
        adv       = 1'b1;
        step_done = 1'b1;
        step_cost = COST_W'(COST_COPY);
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/wdma_engine.sv
module wdma_engine
  import wdma_pkg::*;
#(
  parameter logic [3:0] SRAM_BANK = 4'h1,
  parameter int         COST_TERM = 5,
  parameter int         COST_COPY = 2,
  parameter int         WORD_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [7:0]        io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [19:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              step_done,
  output logic [2:0]        step_cost
);
  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [SRC_W-1:0] src_q;
  logic [DST_W-1:0] dst_q;
  logic [LEN_W-1:0] len_q;
  logic             en_q, dec_q, adv, term;

  wdma_regs #(.WORD_STEP(WORD_STEP)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .adv      (adv),
    .term     (term),
    .src_q    (src_q),
    .dst_q    (dst_q),
    .len_q    (len_q),
    .en_q     (en_q),
    .dec_q    (dec_q)
  );

  wdma_seq #(
    .SRAM_BANK (SRAM_BANK),
    .COST_TERM (COST_TERM),
    .COST_COPY (COST_COPY)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (en_q),
    .src       (src_q),
    .dst       (dst_q),
    .len       (len_q),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .adv       (adv),
    .term      (term),
    .step_done (step_done),
    .step_cost (step_cost)
  );

  assign busy = en_q;
endmodule

// File: rtl/wdma_engine_chk.sv
module wdma_engine_chk #(
  parameter int COST_TERM = 5,
  parameter int COST_COPY = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic [7:0]  io_addr,
  input logic [7:0]  io_rdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic [19:0] mem_addr,
  input logic        busy,
  input logic        step_done,
  input logic [2:0]  step_cost
);
  logic mapped;
  assign mapped = (io_addr inside {8'h40, 8'h41, 8'h42, 8'h44, 8'h45, 8'h46, 8'h47, 8'h48});

  AST_LOW_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr inside {8'h40, 8'h44, 8'h46}) |-> !io_rdata[0]);  // R2

  AST_SRC_HI_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == 8'h42) |-> (io_rdata[7:4] == 4'h0));  // R3

  AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == 8'h48) |-> (io_rdata[5:0] == 6'h0));  // R4

  AST_BUSY_IS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == 8'h48) |-> (io_rdata[7] == busy));  // R9

  AST_STOP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && step_cost == 3'(COST_TERM)) |-> !mem_req);  // R5

  AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && step_cost == 3'(COST_TERM) && !(io_wr && io_addr == 8'h48)) |=> !busy);  // R5

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> (mem_req && mem_we));  // R6

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> $past(mem_req && !mem_we));  // R6

  AST_COPY_ENDS_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && step_cost == 3'(COST_COPY)) |-> (mem_req && mem_we && mem_addr[0]));  // R7

  AST_DST_PORT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr[19:16] == 4'h0));  // R8

  AST_COST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (step_cost == 3'(COST_TERM) || step_cost == 3'(COST_COPY)));  // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (io_rdata == 8'h00));  // R10
endmodule

bind wdma_engine wdma_engine_chk #(
  .COST_TERM (COST_TERM),
  .COST_COPY (COST_COPY)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_wr     (io_wr),
  .io_addr   (io_addr),
  .io_rdata  (io_rdata),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .busy      (busy),
  .step_done (step_done),
  .step_cost (step_cost)
);

// File: tb/tb_wdma_engine.sv
`timescale 1ns/1ps
module tb_wdma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_addr = 8'h00;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        mem_req, mem_we;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        busy, step_done;
  logic [2:0]  step_cost;

  always #2 clk = ~clk;  // 250 MHz

  wdma_engine dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .step_done(step_done),
    .step_cost(step_cost)
  );

  int errors = 0;
  int checks = 0;

  // Memory model: every read returns a byte derived from its address
  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  logic        log_we   [64];
  logic [19:0] log_addr [64];
  logic [7:0]  log_data [64];
  int          nacc = 0;
  int          cost_sum = 0;
  int          nsteps = 0;

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= pat(mem_addr);
    if (rst_n) begin
      if (mem_req) begin
        if (nacc < 64) begin
          log_we[nacc]   = mem_we;
          log_addr[nacc] = mem_addr;
          log_data[nacc] = mem_wdata;
        end
        nacc = nacc + 1;
      end
      if (step_done) begin
        cost_sum = cost_sum + int'(step_cost);
        nsteps   = nsteps + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    io_addr = a;
    #0.5 v = io_rdata;
  endtask

  task automatic rd_regs(output logic [19:0] s, output logic [15:0] d, output logic [15:0] l);
    logic [7:0] b0, b1, b2;
    rd(8'h40, b0); rd(8'h41, b1); rd(8'h42, b2);
    s = {b2[3:0], b1, b0};
    rd(8'h44, b0); rd(8'h45, b1); d = {b1, b0};
    rd(8'h46, b0); rd(8'h47, b1); l = {b1, b0};
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Vector table: {dec, src[19:0], dst[15:0], len[15:0]}
  localparam int NV = 7;
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 20'h23456, 16'h1000, 16'h0006},  // ascending, R6 R7
    {1'b1, 20'h30010, 16'h2000, 16'h0004},  // descending, R7
    {1'b0, 20'hFFFFE, 16'hFFFE, 16'h0004},  // both wrap upward, R8
    {1'b1, 20'h00000, 16'h0000, 16'h0004},  // both wrap downward, R8
    {1'b0, 20'h12340, 16'h3000, 16'h0006},  // source starts in bank 1, R5
    {1'b0, 20'h05000, 16'h4000, 16'h0000},  // zero count, R5
    {1'b0, 20'h0FFFE, 16'h5000, 16'h0004}   // crosses into bank 1, R5
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0]  v;
    logic [19:0] s, es;
    logic [15:0] d, ed, l, el;
    int          base, words, cbase, sbase, k;

    do_reset();

    // R9: reset state
    chk(busy == 1'b0, "R9 busy after reset", busy, 0);
    chk(mem_req == 1'b0, "R9 memory port idle after reset", mem_req, 0);
    foreach (VEC[i]) begin end
    for (int a = 8'h40; a <= 8'h48; a++) begin
      rd(8'(a), v);
      chk(v == 8'h00, $sformatf("R9 reg 0x%0h zero after reset", a), v, 0);
    end

    // R1 R2: byte lanes and forced low bit
    wr(8'h40, 8'h57);
    rd(8'h40, v); chk(v == 8'h56, "R2 src low bit forced", v, 8'h56);
    wr(8'h41, 8'hAB);
    rd(8'h40, v); chk(v == 8'h56, "R1 src low kept on mid write", v, 8'h56);
    rd(8'h41, v); chk(v == 8'hAB, "R1 src mid", v, 8'hAB);
    // R3
    wr(8'h42, 8'hF3);
    rd(8'h42, v); chk(v == 8'h03, "R3 src high nibble", v, 8'h03);
    rd(8'h41, v); chk(v == 8'hAB, "R1 src mid kept on high write", v, 8'hAB);
    wr(8'h45, 8'h12); wr(8'h44, 8'h35);
    rd(8'h44, v); chk(v == 8'h34, "R2 dst low bit forced", v, 8'h34);
    rd(8'h45, v); chk(v == 8'h12, "R1 dst high kept on low write", v, 8'h12);
    wr(8'h47, 8'h00); wr(8'h46, 8'h03);
    rd(8'h46, v); chk(v == 8'h02, "R2 len low bit forced", v, 8'h02);
    // R10
    rd(8'h43, v); chk(v == 8'h00, "R10 unmapped 0x43 reads zero", v, 0);
    rd(8'h49, v); chk(v == 8'h00, "R10 unmapped 0x49 reads zero", v, 0);
    wr(8'h43, 8'hFF);
    rd(8'h42, v); chk(v == 8'h03, "R10 write to 0x43 ignored", v, 8'h03);
    rd(8'h40, v); chk(v == 8'h56, "R10 write to 0x43 ignored (src low)", v, 8'h56);
    // R4
    wr(8'h48, 8'h3F);
    rd(8'h48, v); chk(v == 8'h00, "R4 control low bits dropped", v, 0);
    chk(busy == 1'b0, "R4 busy stays low", busy, 0);

    // Vector loop
    for (int n = 0; n < NV; n++) begin
      logic        dec;
      logic [19:0] vs;
      logic [15:0] vd, vl;
      {dec, vs, vd, vl} = VEC[n];
      base = nacc; cbase = cost_sum; sbase = nsteps;
      wr(8'h40, vs[7:0]);  wr(8'h41, vs[15:8]); wr(8'h42, {4'h0, vs[19:16]});
      wr(8'h44, vd[7:0]);  wr(8'h45, vd[15:8]);
      wr(8'h46, vl[7:0]);  wr(8'h47, vl[15:8]);
      wr(8'h48, {1'b1, dec, 6'b0});
      chk(busy == 1'b1, $sformatf("R9 busy after enable v%0d", n), busy, 1);
      wait_idle();
      // expected transfer, built from the requirements
      es = vs; ed = vd; el = vl; words = 0; k = 0;
      while (el != 16'h0 && es[19:16] != 4'h1) begin
        chk(log_we[base+k] == 1'b0 && log_addr[base+k] == es,
            $sformatf("R6 v%0d read src", n), log_addr[base+k], es);
        chk(log_we[base+k+1] == 1'b1 && log_addr[base+k+1] == {4'h0, ed}
            && log_data[base+k+1] == pat(es),
            $sformatf("R6 v%0d write dst", n), log_data[base+k+1], pat(es));
        chk(log_we[base+k+2] == 1'b0 && log_addr[base+k+2] == (es | 20'h1),
            $sformatf("R6 v%0d read src+1", n), log_addr[base+k+2], es | 20'h1);
        chk(log_we[base+k+3] == 1'b1 && log_addr[base+k+3] == {4'h0, ed | 16'h1}
            && log_data[base+k+3] == pat(es | 20'h1),
            $sformatf("R6 v%0d write dst+1", n), log_data[base+k+3], pat(es | 20'h1));
        es = dec ? es - 20'd2 : es + 20'd2;
        ed = dec ? ed - 16'd2 : ed + 16'd2;
        el = el - 16'd2;
        words++; k += 4;
      end
      chk(nacc - base == 4 * words, $sformatf("R5 R6 v%0d access count", n), nacc - base, 4 * words);
      chk(cost_sum - cbase == 2 * words + 5, $sformatf("R5 R7 v%0d cost total", n),
          cost_sum - cbase, 2 * words + 5);
      chk(nsteps - sbase == words + 1, $sformatf("R7 v%0d step count", n), nsteps - sbase, words + 1);
      rd_regs(s, d, l);
      chk(s == es, $sformatf("R7 R8 v%0d final src", n), s, es);
      chk(d == ed, $sformatf("R7 R8 v%0d final dst", n), d, ed);
      chk(l == el, $sformatf("R7 v%0d final len", n), l, el);
      chk(busy == 1'b0, $sformatf("R5 v%0d enable cleared", n), busy, 0);
    end

    // R5: decrement flag survives the stop step
    wr(8'h46, 8'h00); wr(8'h47, 8'h00);
    wr(8'h48, 8'hC0);
    wait_idle();
    rd(8'h48, v); chk(v == 8'h40, "R5 decrement flag kept, enable cleared", v, 8'h40);

    // R9: reset in the middle of a long transfer
    wr(8'h40, 8'h00); wr(8'h41, 8'h00); wr(8'h42, 8'h02);
    wr(8'h46, 8'h00); wr(8'h47, 8'h01);
    wr(8'h48, 8'h80);
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R9 busy during long transfer", busy, 1);
    do_reset();
    chk(busy == 1'b0, "R9 busy cleared by reset", busy, 0);
    chk(mem_req == 1'b0, "R9 port idle after reset", mem_req, 0);
    rd_regs(s, d, l);
    chk(s == 20'h0 && d == 16'h0 && l == 16'h0, "R9 registers cleared by reset", s ^ d ^ l, 0);
    rd(8'h48, v); chk(v == 8'h00, "R9 control cleared by reset", v, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule